// File: doc/BRIEF.md
# I2C Register Transaction Master

This block is a bus master for a two-wire serial bus with open-drain clock and data lines. One start strobe runs a whole register transaction on the wire. A write sends the device address with the write direction, then the register address, then one data byte, and closes with a stop. A read sends the device address with the write direction and then the register address. It follows with a repeated start and no stop between, sends the device address with the read direction, and shifts in one byte. It answers that byte with a not-acknowledge and then issues a stop.

Both lines are only ever pulled low or released. The outputs are drive-low enables, and an external pull-up supplies the high level. Bus timing comes from a clock enable that divides each bit into four equal quarters of `QTR_CLKS` system clocks. Choose `QTR_CLKS` so that one bit lasts at least 2.5 µs, which keeps the clock at or below 400 kHz. A slave that does not pull data low during the ninth clock within `ACK_TMO` system clocks ends the transaction: the block issues a stop and raises the error flag. The flag stays set until the next accepted start strobe.

Top module: `i2c_regxfer_master`

## Requirements
- R1: After reset, and whenever no transaction is running, both drive-low enables are 0 (lines released), `done_o` is 0 and `err_o` is 0 until a failure occurs.
- R2: The first byte after every start or repeated start is the 7-bit device address followed by a direction bit, sent most significant bit first, with 0 for write and 1 for read. Device 0x68 therefore appears as 0xD0 for writing and 0xD1 for reading.
- R3: The data line changes only while the clock line is low, except in the two framing events. A start is the data line falling while the clock is high, and a stop is the data line rising while the clock is high. A write transaction has exactly one start and one stop.
- R4: A write (`rd_i`=0) places the data byte in the addressed register of the slave. When all three bytes are acknowledged, it ends with a stop, then `done_o` high for exactly one cycle with `err_o`=0.
- R5: A read (`rd_i`=1) shows two starts and only one stop: a repeated start follows the register address with no stop between. `rdata_o` holds the byte read when `done_o` pulses.
- R6: During the ninth clock of the byte read, the master leaves the data line released (not-acknowledge) and then issues a stop.
- R7: If the data line is still high when the ninth clock is high, the master keeps the clock high for at most `ACK_TMO` more system clocks. It then issues a stop, sets `err_o` to 1 and pulses `done_o`.
- R8: `err_o` holds its value until the next start strobe is accepted. The strobe clears it.
- R9: While a transaction runs with acknowledging slaves, consecutive rising clock edges are exactly `4*QTR_CLKS` system clocks apart, including across the repeated start and the stop.
- R10: A start strobe that arrives while a transaction is running is ignored. It causes no further start on the wire, and the running transaction's address, direction and data are not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| rd_i | input | 1 | 1 selects a register read, 0 a register write |
| dev_addr_i | input | 7 | Slave device address |
| reg_addr_i | input | 8 | Register address within the slave |
| wdata_i | input | 8 | Byte to write |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| rdata_o | output | 8 | Byte returned by a read |
| done_o | output | 1 | One-cycle pulse at the end of a transaction |
| err_o | output | 1 | Missing acknowledge, held until next start |

## Verification
The hardest condition to reach is the acknowledge timeout. The clock has to be held high during the ninth bit while nothing pulls the data line low, and the block must then leave that state through a stop and not through a stuck bus. The bench reaches it by addressing a device number that its slave model does not answer, for both directions. It measures the clock high time of that ninth bit against the limit, and then confirms that the sticky error survives idle cycles and is cleared by a following good transaction. The other hard case is the repeated start. The bench reaches it by sweeping register reads, and the slave model logs the first byte after each start and the master's answer to the read byte.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int DEV_W  = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_WBIT,
    PH_WACK,
    PH_RSTART,
    PH_RBIT,
    PH_MNACK,
    PH_STOP
  } phase_e;
endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int QTR_CLKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick_o = run_i && (cnt_q == CW'(QTR_CLKS - 1));

  always_comb begin
    if (!run_i || tick_o) cnt_n = '0;
    else                  cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  generate
    if (QTR_CLKS > 1) begin : g_spacing
      // R9
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/i2c_acktmo.sv
module i2c_acktmo #(
  parameter int ACK_TMO = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int TW = $clog2(ACK_TMO + 1);

  logic [TW-1:0] cnt_q, cnt_n;

  assign expired_o = run_i && (cnt_q == TW'(ACK_TMO - 1));

  always_comb begin
    if (!run_i)         cnt_n = '0;
    else if (expired_o) cnt_n = cnt_q;
    else                cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/i2c_regxfer_master.sv
module i2c_regxfer_master
  import i2c_rx_pkg::*;
#(
  parameter int QTR_CLKS = 250,
  parameter int ACK_TMO  = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [DEV_W-1:0]  dev_addr_i,
  input  logic [BYTE_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // two-stage synchronizer for the sensed data line
  logic [1:0] sda_sq;
  logic       sda_s;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sda_sq <= 2'b11;
    else        sda_sq <= {sda_sq[0], sda_i};
  end
  assign sda_s = sda_sq[1];

  phase_e            ph_q, ph_n;
  logic [1:0]        qtr_q, qtr_n, idx_q, idx_n;
  logic [2:0]        bit_q, bit_n;
  logic [BYTE_W-1:0] sh_q, sh_n, rdat_q, rdat_n, reg_q, reg_n, wd_q, wd_n;
  logic [DEV_W-1:0]  dev_q, dev_n;
  logic              rd_q, rd_n, wait_q, wait_n, err_q, err_n, done_q, done_n;
  logic              scl_rel_q, scl_rel_n, sda_rel_q, sda_rel_n;
  logic              tick, tmo_exp;

  i2c_qtick #(.QTR_CLKS(QTR_CLKS)) u_qtick (
    .clk(clk), .rst_n(rst_i), .run_i((ph_q != PH_IDLE) && !wait_q), .tick_o(tick));

  i2c_acktmo #(.ACK_TMO(ACK_TMO)) u_acktmo (
    .clk(clk), .rst_n(rst_i), .run_i(wait_q), .expired_o(tmo_exp));

  function automatic logic [BYTE_W-1:0] pick(input logic [1:0] i);
    case (i)
      2'd0:    pick = {dev_q, 1'b0};
      2'd1:    pick = reg_q;
      default: pick = rd_q ? {dev_q, 1'b1} : wd_q;
    endcase
  endfunction

  // sequencing
  always_comb begin
    ph_n = ph_q; qtr_n = qtr_q; idx_n = idx_q; bit_n = bit_q; sh_n = sh_q;
    rdat_n = rdat_q; dev_n = dev_q; reg_n = reg_q; wd_n = wd_q; rd_n = rd_q;
    wait_n = wait_q; err_n = err_q; done_n = 1'b0;
    if (ph_q == PH_IDLE) begin
      if (start_i) begin
        dev_n = dev_addr_i; reg_n = reg_addr_i; wd_n = wdata_i; rd_n = rd_i;
        err_n = 1'b0; ph_n = PH_START; qtr_n = 2'd0;
      end
    end else if (wait_q) begin
      if (!sda_s) begin
        wait_n = 1'b0; qtr_n = 2'd3;
      end else if (tmo_exp) begin
        wait_n = 1'b0; err_n = 1'b1; ph_n = PH_STOP; qtr_n = 2'd0;
      end
    end else if (tick) begin
      qtr_n = qtr_q + 2'd1;
      if (ph_q == PH_WACK && qtr_q == 2'd2 && sda_s) begin
        wait_n = 1'b1; qtr_n = qtr_q;
      end
      if (ph_q == PH_RBIT && qtr_q == 2'd2) sh_n = {sh_q[BYTE_W-2:0], sda_s};
      if (qtr_q == 2'd3) begin
        case (ph_q)
          PH_START: begin ph_n = PH_WBIT; idx_n = 2'd0; bit_n = 3'd0; sh_n = pick(2'd0); end
          PH_WBIT: begin
            sh_n = {sh_q[BYTE_W-2:0], 1'b0};
            if (bit_q == 3'd7) ph_n = PH_WACK;
            else               bit_n = bit_q + 3'd1;
          end
          PH_WACK: begin
            if (!rd_q && idx_q == 2'd2)     ph_n = PH_STOP;
            else if (rd_q && idx_q == 2'd1) ph_n = PH_RSTART;
            else if (rd_q && idx_q == 2'd2) begin ph_n = PH_RBIT; bit_n = 3'd0; end
            else begin
              ph_n = PH_WBIT; bit_n = 3'd0; idx_n = idx_q + 2'd1; sh_n = pick(idx_q + 2'd1);
            end
          end
          PH_RSTART: begin ph_n = PH_WBIT; idx_n = 2'd2; bit_n = 3'd0; sh_n = pick(2'd2); end
          PH_RBIT: begin
            if (bit_q == 3'd7) begin ph_n = PH_MNACK; rdat_n = sh_q; end
            else               bit_n = bit_q + 3'd1;
          end
          PH_MNACK: ph_n = PH_STOP;
          PH_STOP:  begin ph_n = PH_IDLE; done_n = 1'b1; end
          default:  ph_n = PH_IDLE;
        endcase
      end
    end
  end

  // line levels: the clock is high in quarters 2..3; data moves in quarter 1
  always_comb begin
    scl_rel_n = qtr_q[1];
    sda_rel_n = sda_rel_q;
    case (ph_q)
      PH_IDLE:   begin scl_rel_n = 1'b1; sda_rel_n = 1'b1; end
      PH_START:  begin scl_rel_n = 1'b1; sda_rel_n = !qtr_q[1]; end
      PH_RSTART: if (qtr_q != 2'd0) sda_rel_n = (qtr_q != 2'd3);
      PH_STOP:   if (qtr_q != 2'd0) sda_rel_n = (qtr_q == 2'd3);
      PH_WBIT:   if (qtr_q != 2'd0) sda_rel_n = sh_q[BYTE_W-1];
      default:   if (qtr_q != 2'd0) sda_rel_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ph_q <= PH_IDLE; qtr_q <= '0; idx_q <= '0; bit_q <= '0; sh_q <= '0;
      rdat_q <= '0; dev_q <= '0; reg_q <= '0; wd_q <= '0; rd_q <= 1'b0;
      wait_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0;
      scl_rel_q <= 1'b1; sda_rel_q <= 1'b1;
    end else begin
      ph_q <= ph_n; qtr_q <= qtr_n; idx_q <= idx_n; bit_q <= bit_n; sh_q <= sh_n;
      rdat_q <= rdat_n; dev_q <= dev_n; reg_q <= reg_n; wd_q <= wd_n; rd_q <= rd_n;
      wait_q <= wait_n; err_q <= err_n; done_q <= done_n;
      scl_rel_q <= scl_rel_n; sda_rel_q <= sda_rel_n;
    end
  end

  assign scl_oe_o = !scl_rel_q;
  assign sda_oe_o = !sda_rel_q;
  assign rdata_o  = rdat_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  // R1
  idle_rel_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ph_q == PH_IDLE && $past(ph_q) == PH_IDLE) |-> (scl_rel_q && sda_rel_q));
  // R3
  sda_hi_chg_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (scl_rel_q && $past(scl_rel_q) && (sda_rel_q != $past(sda_rel_q)))
      |-> ($past(ph_q) inside {PH_START, PH_RSTART, PH_STOP}));
  // R6
  mnack_rel_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ph_q == PH_MNACK && qtr_q != 2'd0) |=> sda_rel_q);
  // R7
  tmo_stop_chk: assert property (@(posedge clk) disable iff (!rst_i)
    tmo_exp |=> (ph_q == PH_STOP && err_q));
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (err_q && !(start_i && ph_q == PH_IDLE)) |=> err_q);
  // R10
  busy_ign_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ph_q != PH_IDLE) |=> ($stable(dev_q) && $stable(reg_q) && $stable(wd_q) && $stable(rd_q)));
endmodule

// File: tb/i2c_regxfer_master_tb_top.sv
`timescale 1ns/1ps
module i2c_regxfer_master_tb_top;
  localparam int QTR = 4;
  localparam int TMO = 40;
  localparam logic [6:0] SLV = 7'h68;
  localparam real TCK = 5.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0;
  logic [6:0] dev = '0;
  logic [7:0] regad = '0, wd = '0;
  logic scl_oe, sda_oe, done, err;
  logic [7:0] rdata;
  logic sl_drv = 1'b0;
  logic sda_line, scl_line;

  assign sda_line = !(sda_oe || sl_drv);
  assign scl_line = !scl_oe;

  always #2.5 clk = ~clk;

  i2c_regxfer_master #(.QTR_CLKS(QTR), .ACK_TMO(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_i(rd), .dev_addr_i(dev),
    .reg_addr_i(regad), .wdata_i(wd), .sda_i(sda_line), .scl_oe_o(scl_oe),
    .sda_oe_o(sda_oe), .rdata_o(rdata), .done_o(done), .err_o(err));

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // slave model and bus monitor
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] fb [4];
  logic [7:0] sl_sh = '0, sl_txb = '0, sl_ptr = '0;
  int sl_bit = 0, sl_idx = 0;
  bit sl_on = 0, sl_tx = 0, sl_go = 0, sl_hit = 0;
  logic mack = 1'b0;
  logic p_scl = 1'bx, p_sda = 1'bx;
  int n_start = 0, n_stop = 0;
  bit have_rise = 0;
  realtime t_rise = 0, per_min = 1.0e9, per_max = 0, hi_max = 0;

  always @(scl_line or sda_line) begin
    if (scl_line !== p_scl) begin
      if (scl_line === 1'b1) begin
        if (have_rise) begin
          if ($realtime - t_rise < per_min) per_min = $realtime - t_rise;
          if ($realtime - t_rise > per_max) per_max = $realtime - t_rise;
        end
        t_rise = $realtime; have_rise = 1;
        if (sl_on) begin
          if (sl_bit < 8) sl_sh = {sl_sh[6:0], sda_line};
          else if (sl_bit == 8 && sl_tx) begin mack = sda_line; sl_go = !sda_line; end
          sl_bit++;
        end
      end else if (scl_line === 1'b0) begin
        if (have_rise && ($realtime - t_rise > hi_max)) hi_max = $realtime - t_rise;
        if (sl_on) begin
          if (sl_bit == 8) begin
            if (sl_tx) sl_drv = 1'b0;
            else begin
              if (sl_idx == 0) begin
                if (n_start >= 1 && n_start <= 4) fb[n_start-1] = sl_sh;
                sl_hit = (sl_sh[7:1] == SLV);
                sl_go = sl_hit && sl_sh[0];
              end else if (sl_hit && sl_idx == 1) sl_ptr = sl_sh;
              else if (sl_hit) begin mem[sl_ptr] = sl_sh; sl_ptr++; end
              sl_drv = sl_hit;
            end
          end else if (sl_bit == 9) begin
            sl_bit = 0; sl_idx++; sl_drv = 1'b0; sl_tx = 0;
            if (sl_go) begin
              sl_tx = 1; sl_go = 0; sl_txb = mem[sl_ptr]; sl_ptr++;
              sl_drv = !sl_txb[7];
            end
          end else if (sl_tx && sl_bit >= 1 && sl_bit <= 7) sl_drv = !sl_txb[7-sl_bit];
        end
      end
    end else if (sda_line !== p_sda && scl_line === 1'b1 && p_sda !== 1'bx) begin
      if (sda_line === 1'b0) begin
        n_start++; sl_on = 1; sl_bit = 0; sl_idx = 0; sl_tx = 0; sl_go = 0; sl_hit = 0;
        sl_drv = 1'b0;
      end else begin
        n_stop++; sl_on = 0; sl_drv = 1'b0;
      end
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  task automatic clear_mon();
    n_start = 0; n_stop = 0; have_rise = 0; per_min = 1.0e9; per_max = 0; hi_max = 0;
    mack = 1'b0;
    for (int i = 0; i < 4; i++) fb[i] = 8'h00;
  endtask

  task automatic pulse_start(input bit r, input logic [6:0] d, input logic [7:0] ra,
                             input logic [7:0] w);
    @(negedge clk);
    start = 1'b1; rd = r; dev = d; regad = ra; wd = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done; reports whether it came and whether it lasted one cycle
  task automatic wait_done(output bit got, output bit one_cyc);
    got = 0; one_cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
    @(negedge clk);
    one_cyc = got && !done;
  endtask

  task automatic do_write(input logic [6:0] d, input logic [7:0] ra, input logic [7:0] w,
                          output bit got, output bit one_cyc, output bit err_clr);
    clear_mon();
    pulse_start(1'b0, d, ra, w);
    err_clr = !err;
    wait_done(got, one_cyc);
  endtask

  task automatic do_read(input logic [6:0] d, input logic [7:0] ra,
                         output bit got, output bit one_cyc);
    bit dummy;
    clear_mon();
    pulse_start(1'b1, d, ra, 8'h00);
    dummy = !err;
    wait_done(got, one_cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit got, one, eclr;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset / idle state
    chk(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
    chk(!done && !err, "R1 done/err low after reset", {done, err}, 0);

    // write sweep over registers spread across the address space
    for (int r = 0; r < 16; r++) begin
      logic [7:0] ra, w;
      ra = 8'(r * 17);
      w  = 8'((r * 73 + 11) & 8'hff);
      do_write(SLV, ra, w, got, one, eclr);
      exp_mem[ra] = w;
      chk(got && one, "R4 write done single-cycle pulse", {got, one}, 3);
      chk(!err, "R4 write err", err, 0);
      chk(mem[ra] == w, "R4 slave register contents", mem[ra], w);
      chk(fb[0] == {SLV, 1'b0}, "R2 first byte write dir", fb[0], {SLV, 1'b0});
      chk(n_start == 1 && n_stop == 1, "R3 one start one stop", n_start*16 + n_stop, 17);
      chk(per_min == 4*QTR*TCK && per_max == 4*QTR*TCK, "R9 clock period",
          int'(per_max), int'(4*QTR*TCK));
      chk(!scl_oe && !sda_oe, "R1 released when idle", {scl_oe, sda_oe}, 0);
    end

    // read sweep, including one never-written register
    for (int r = 0; r < 17; r++) begin
      logic [7:0] ra;
      ra = (r == 16) ? 8'h01 : 8'(r * 17);
      do_read(SLV, ra, got, one);
      chk(got && one, "R5 read done single-cycle pulse", {got, one}, 3);
      chk(rdata == exp_mem[ra], "R5 read data", rdata, exp_mem[ra]);
      chk(!err, "R5 read err", err, 0);
      chk(n_start == 2 && n_stop == 1, "R5 repeated start, single stop",
          n_start*16 + n_stop, 33);
      chk(fb[0] == {SLV, 1'b0}, "R2 read first byte write dir", fb[0], {SLV, 1'b0});
      chk(fb[1] == {SLV, 1'b1}, "R2 after repeated start read dir", fb[1], {SLV, 1'b1});
      chk(mack === 1'b1, "R6 master nack on read byte", mack, 1);
      chk(per_min == 4*QTR*TCK && per_max == 4*QTR*TCK, "R9 clock period read",
          int'(per_max), int'(4*QTR*TCK));
    end

    // R7: missing acknowledge, both directions
    for (int dir = 0; dir < 2; dir++) begin
      clear_mon();
      pulse_start(dir[0], 7'h22, 8'h10, 8'h5A);
      wait_done(got, one);
      chk(got && one, "R7 done after timeout", {got, one}, 3);
      chk(err, "R7 err set on timeout", err, 1);
      chk(n_start == 1 && n_stop == 1, "R7 stop after timeout", n_start*16 + n_stop, 17);
      chk(fb[0] == {7'h22, 1'b0}, "R7 address byte sent", fb[0], {7'h22, 1'b0});
      chk(hi_max >= (QTR + TMO - 1) * TCK && hi_max <= (QTR + TMO + 4) * TCK,
          "R7 ninth clock high time", int'(hi_max), int'((QTR + TMO) * TCK));
      chk(mem[8'h10] == exp_mem[8'h10], "R7 no register write", mem[8'h10], exp_mem[8'h10]);
      repeat (30) @(negedge clk);
      chk(err, "R8 err held while idle", err, 1);
    end

    // R8: next accepted strobe clears err
    do_write(SLV, 8'h33, 8'hC3, got, one, eclr);
    exp_mem[8'h33] = 8'hC3;
    chk(eclr, "R8 err cleared by strobe", !eclr, 0);
    chk(got && !err && mem[8'h33] == 8'hC3, "R8 good transfer after error", mem[8'h33], 8'hC3);

    // R10: strobe while busy is ignored
    clear_mon();
    pulse_start(1'b0, SLV, 8'h05, 8'hA5);
    repeat (100) @(negedge clk);
    start = 1'b1; rd = 1'b1; dev = 7'h11; regad = 8'h06; wd = 8'h3C;
    @(negedge clk);
    start = 1'b0;
    wait_done(got, one);
    exp_mem[8'h05] = 8'hA5;
    repeat (50) @(negedge clk);
    chk(n_start == 1 && n_stop == 1, "R10 no extra transaction", n_start*16 + n_stop, 17);
    chk(mem[8'h05] == 8'hA5, "R10 original data written", mem[8'h05], 8'hA5);
    chk(mem[8'h06] == exp_mem[8'h06], "R10 other register untouched", mem[8'h06], exp_mem[8'h06]);
    chk(!done && !scl_oe && !sda_oe, "R1 idle after ignored strobe", {done, scl_oe, sda_oe}, 0);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule